// File: doc/BRIEF.md
# Mailbox Boot Loader Receiver

This block is the receiving half of a boot loader, built as a hardware state machine on the sound-processor side. A host processor talks to it through four byte-wide mailbox ports. Each port has two registers, one for each direction. The host writes command, address and payload bytes into its inbound registers. The loader answers through its outbound registers. Out of reset the loader posts a ready signature on the two low ports, then waits for the host to open a session.

A session is a series of commands, and each command is triggered by a write to port 0. A non-zero command byte on port 1 opens a code block. The destination address is taken from port 2 (low byte) and port 3 (high byte). Each payload byte is then given by writing it to port 1 and writing a per-block byte counter to port 0. The loader stores the byte through a simple RAM write port and echoes the counter back on port 0. If a port 0 value does not match the expected counter, it starts a new command. A command byte of zero ends loading and presents the entry address taken from ports 2 and 3 on the start output.

Top module: `mbl_boot_rx`

## Requirements
- R1: After reset the host reads 0xAA on port 0, 0xBB on port 1 and 0x00 on ports 2 and 3. `ram_we_o` is low and `start_o` is low.
- R2: `host_rdata_o` is 0x00 whenever `host_rd_i` is low. When `host_rd_i` is high, it shows the loader's outbound register selected by `host_addr_i`, with no delay.
- R3: Before a session opens, a write to port 0 of any value other than 0xCC has no effect. Port 0 keeps reading 0xAA and no RAM write occurs.
- R4: A port 0 write captured at clock edge N is acted on at edge N+1. When the session opens with 0xCC, port 0 reads 0xCC after edge N+1.
- R5: A non-zero command byte on port 1 opens a block. The first byte goes to address {port 3, port 2}, and the expected counter restarts at 0.
- R6: Inside a block, a port 0 value equal to the expected counter is accepted. The port 1 byte is written to RAM at the running address, the address and the expected counter both advance by one, and the counter value is echoed on port 0.
- R7: Inside a block, a port 0 value different from the expected counter is echoed on port 0 and makes the loader decode port 1 as a new command. No RAM write occurs for it.
- R8: The running RAM address wraps from 0xFFFF to 0x0000.
- R9: A command byte of zero raises `start_o`, which then stays high until reset. `entry_addr_o` then holds {port 3, port 2} and stays stable.
- R10: Once `start_o` is high, host writes have no effect. Port 0 keeps its last echo and no RAM write occurs.
- R11: `ram_we_o` pulses for exactly one cycle per accepted byte, in the same cycle as that byte's echo, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host write strobe into the inbound register selected by host_addr_i |
| host_rd_i | input | 1 | Host read strobe; enables host_rdata_o |
| host_addr_i | input | 2 | Port select, 0 to 3 |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Outbound register of the selected port, or zero |
| ram_we_o | output | 1 | RAM write enable, one cycle per byte |
| ram_addr_o | output | 16 | RAM write address |
| ram_wdata_o | output | 8 | RAM write data |
| start_o | output | 1 | Loading finished; entry address valid |
| entry_addr_o | output | 16 | Entry address for the loaded code |

## Verification
Some properties are checked on every cycle. A RAM write always traces back to a port 0 write two cycles earlier. `start_o` is sticky and `entry_addr_o` is stable once it is set. No RAM write follows start. The read data is zero while the read strobe is low. The bench scenarios must show the rest: ignored pre-session writes, counter matching versus command detection, block restart addresses, the wrap at 0xFFFF, and the exact echo values. A behavioural reference model tracks these, and every cycle's outputs are compared against it.

// File: rtl/mbl_pkg.sv
package mbl_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_LOAD = 2'd1,
    ST_GO   = 2'd2
  } ldr_state_e;
endpackage

// File: rtl/mbl_port_bank.sv
module mbl_port_bank #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DW        = 8,
  parameter logic [DW-1:0] RDY0    = 8'hAA,
  parameter logic [DW-1:0] RDY1    = 8'hBB,
  localparam int unsigned PAW      = $clog2(NUM_PORTS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          host_wr_i,
  input  logic                          host_rd_i,
  input  logic [PAW-1:0]                host_addr_i,
  input  logic [DW-1:0]                 host_wdata_i,
  output logic [DW-1:0]                 host_rdata_o,
  input  logic                          echo_we_i,
  input  logic [DW-1:0]                 echo_val_i,
  output logic [NUM_PORTS-1:0][DW-1:0]  in_q_o,
  output logic                          kick_o
);
  logic [DW-1:0] out_q [NUM_PORTS];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    localparam logic [DW-1:0] INIT = (g == 0) ? RDY0 : (g == 1) ? RDY1 : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) in_q_o[g] <= '0;
      else if (host_wr_i && host_addr_i == PAW'(g)) in_q_o[g] <= host_wdata_i;
    end

    if (g == 0) begin : g_echo
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        out_q[g] <= INIT;
        else if (echo_we_i) out_q[g] <= echo_val_i;
      end
    end else begin : g_fixed
      assign out_q[g] = INIT;
    end
  end

  // port 0 write is the event that drives the loader
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kick_o <= 1'b0;
    else         kick_o <= host_wr_i && (host_addr_i == '0);
  end

  assign host_rdata_o = host_rd_i ? out_q[host_addr_i] : '0;
endmodule

// File: rtl/mbl_load_ctrl.sv
module mbl_load_ctrl
  import mbl_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned AW      = 16,
  parameter logic [DW-1:0] KICK  = 8'hCC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          kick_i,
  input  logic [DW-1:0] p0_i,
  input  logic [DW-1:0] p1_i,
  input  logic [DW-1:0] p2_i,
  input  logic [DW-1:0] p3_i,
  output logic          echo_we_o,
  output logic [DW-1:0] echo_val_o,
  output logic          blk_load_o,
  output logic [AW-1:0] blk_addr_o,
  output logic          byte_we_o,
  output logic [DW-1:0] byte_o,
  output logic          start_o,
  output logic [AW-1:0] entry_o
);
  ldr_state_e    state_q, state_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] entry_q, entry_d;
  logic          decode;

  assign blk_addr_o = AW'({p3_i, p2_i});
  assign byte_o     = p1_i;
  assign echo_val_o = p0_i;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    entry_d    = entry_q;
    echo_we_o  = 1'b0;
    blk_load_o = 1'b0;
    byte_we_o  = 1'b0;
    decode     = 1'b0;
    if (kick_i) begin
      unique case (state_q)
        ST_WAIT: if (p0_i == KICK) begin
          echo_we_o = 1'b1;
          decode    = 1'b1;
        end
        ST_LOAD: begin
          echo_we_o = 1'b1;
          if (p0_i == cnt_q) begin
            byte_we_o = 1'b1;
            cnt_d     = cnt_q + 1'b1;
          end else begin
            decode = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (decode) begin
      if (p1_i != '0) begin
        blk_load_o = 1'b1;
        cnt_d      = '0;
        state_d    = ST_LOAD;
      end else begin
        entry_d = AW'({p3_i, p2_i});
        state_d = ST_GO;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      entry_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      entry_q <= entry_d;
    end
  end

  assign start_o = (state_q == ST_GO);
  assign entry_o = entry_q;
endmodule

// File: rtl/mbl_ram_wr.sv
module mbl_ram_wr #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          byte_we_i,
  input  logic [DW-1:0] byte_i,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o
);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q       <= '0;
      ram_we_o    <= 1'b0;
      ram_addr_o  <= '0;
      ram_wdata_o <= '0;
    end else begin
      ram_we_o <= byte_we_i;
      if (load_i) begin
        ptr_q <= load_addr_i;
      end else if (byte_we_i) begin
        ram_addr_o  <= ptr_q;
        ram_wdata_o <= byte_i;
        ptr_q       <= ptr_q + 1'b1;  // wraps at top of space
      end
    end
  end
endmodule

// File: rtl/mbl_boot_rx.sv
module mbl_boot_rx #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter logic [DATA_W-1:0] RDY0 = 8'hAA,
  parameter logic [DATA_W-1:0] RDY1 = 8'hBB,
  parameter logic [DATA_W-1:0] KICK = 8'hCC
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         host_wr_i,
  input  logic                         host_rd_i,
  input  logic [$clog2(NUM_PORTS)-1:0] host_addr_i,
  input  logic [DATA_W-1:0]            host_wdata_i,
  output logic [DATA_W-1:0]            host_rdata_o,
  output logic                         ram_we_o,
  output logic [ADDR_W-1:0]            ram_addr_o,
  output logic [DATA_W-1:0]            ram_wdata_o,
  output logic                         start_o,
  output logic [ADDR_W-1:0]            entry_addr_o
);
  logic [NUM_PORTS-1:0][DATA_W-1:0] in_q;
  logic                kick;
  logic                echo_we;
  logic [DATA_W-1:0]   echo_val;
  logic                blk_load;
  logic [ADDR_W-1:0]   blk_addr;
  logic                byte_we;
  logic [DATA_W-1:0]   byte_d;

  mbl_port_bank #(
    .NUM_PORTS(NUM_PORTS), .DW(DATA_W), .RDY0(RDY0), .RDY1(RDY1)
  ) u_bank (
    .clk_i, .rst_ni, .host_wr_i, .host_rd_i, .host_addr_i, .host_wdata_i,
    .host_rdata_o,
    .echo_we_i (echo_we),
    .echo_val_i(echo_val),
    .in_q_o    (in_q),
    .kick_o    (kick)
  );

  mbl_load_ctrl #(.DW(DATA_W), .AW(ADDR_W), .KICK(KICK)) u_ctrl (
    .clk_i, .rst_ni,
    .kick_i    (kick),
    .p0_i      (in_q[0]),
    .p1_i      (in_q[1]),
    .p2_i      (in_q[2]),
    .p3_i      (in_q[3]),
    .echo_we_o (echo_we),
    .echo_val_o(echo_val),
    .blk_load_o(blk_load),
    .blk_addr_o(blk_addr),
    .byte_we_o (byte_we),
    .byte_o    (byte_d),
    .start_o,
    .entry_o   (entry_addr_o)
  );

  mbl_ram_wr #(.DW(DATA_W), .AW(ADDR_W)) u_wr (
    .clk_i, .rst_ni,
    .load_i     (blk_load),
    .load_addr_i(blk_addr),
    .byte_we_i  (byte_we),
    .byte_i     (byte_d),
    .ram_we_o, .ram_addr_o, .ram_wdata_o
  );
endmodule

// File: rtl/mbl_boot_rx_chk.sv
module mbl_boot_rx_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         host_wr_i,
  input logic                         host_rd_i,
  input logic [$clog2(NUM_PORTS)-1:0] host_addr_i,
  input logic [DATA_W-1:0]            host_wdata_i,
  input logic [DATA_W-1:0]            host_rdata_o,
  input logic                         ram_we_o,
  input logic [ADDR_W-1:0]            ram_addr_o,
  input logic [DATA_W-1:0]            ram_wdata_o,
  input logic                         start_o,
  input logic [ADDR_W-1:0]            entry_addr_o
);
  logic p0_wr;
  assign p0_wr = host_wr_i && (host_addr_i == '0);

  // R2
  rd_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |-> host_rdata_o == '0);

  // R11
  we_from_kick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> $past(p0_wr, 2));

  // R9
  start_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> start_o);

  // R9
  entry_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> $stable(entry_addr_o));

  // R9
  start_from_kick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(p0_wr, 2));

  // R10
  no_we_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !ram_we_o);

  // R10
  ram_quiet_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> $stable(ram_addr_o) && $stable(ram_wdata_o));
endmodule

bind mbl_boot_rx mbl_boot_rx_chk #(
  .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/mbl_boot_rx_bench.sv
module mbl_boot_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd;
  logic [1:0]  host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic        ram_we, start;
  logic [15:0] ram_addr, entry_addr;
  logic [7:0]  ram_wdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbl_boot_rx u_mbl_boot_rx (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_rd_i(host_rd), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .start_o(start), .entry_addr_o(entry_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: behavioural, one step per clock
  int        m_st;        // 0 waiting, 1 loading, 2 started
  int        m_cnt, m_ptr, m_entry;
  bit        m_pend, m_we, m_go;
  int        m_waddr, m_wdata, m_out0;
  int        m_in[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ptr = 0; m_entry = 0; m_pend = 0;
      m_we = 0; m_go = 0; m_out0 = 'hAA;
      foreach (m_in[i]) m_in[i] = 0;
    end else begin
      bit dec;
      dec  = 0;
      m_we = 0;
      if (m_pend) begin
        if (m_st == 0 && m_in[0] == 'hCC) begin
          m_out0 = m_in[0]; dec = 1;
        end else if (m_st == 1) begin
          m_out0 = m_in[0];
          if (m_in[0] == m_cnt) begin
            m_we = 1; m_waddr = m_ptr; m_wdata = m_in[1];
            m_ptr = (m_ptr + 1) % 65536;
            m_cnt = (m_cnt + 1) % 256;
          end else dec = 1;
        end
        if (dec) begin
          if (m_in[1] != 0) begin
            m_st = 1; m_cnt = 0; m_ptr = m_in[3] * 256 + m_in[2];
          end else begin
            m_st = 2; m_go = 1; m_entry = m_in[3] * 256 + m_in[2];
          end
        end
      end
      m_pend = 0;
      if (host_wr) begin
        m_in[host_addr] = host_wdata;
        if (host_addr == 0) m_pend = 1;
      end
    end
  end

  byte unsigned mem [int];
  int wr_cnt = 0;

  always @(posedge clk) begin
    #(Q);
    if (rst_n) begin
      int exp_rd;
      exp_rd = !host_rd ? 0 : host_addr == 0 ? m_out0 : host_addr == 1 ? 'hBB : 0;
      chk(host_rdata == exp_rd, "R2 cycle rdata", host_rdata, exp_rd);
      // R11 per-cycle write enable
      chk(ram_we == m_we, "R11 cycle we", ram_we, m_we);
      if (m_we) begin
        chk(ram_addr == m_waddr, "R6 cycle addr", ram_addr, m_waddr);
        chk(ram_wdata == m_wdata, "R6 cycle data", ram_wdata, m_wdata);
      end
      chk(start == m_go, "R9 cycle start", start, m_go);
      if (m_go) chk(entry_addr == m_entry, "R9 cycle entry", entry_addr, m_entry);
      if (ram_we) begin
        mem[ram_addr] = ram_wdata;
        wr_cnt++;
      end
    end
  end

  task automatic host_write(input int a, input int d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = 2'(a); host_wdata = 8'(d);
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_port(input int a, input int exp, input string tag);
    @(negedge clk);
    host_rd = 1'b1; host_addr = 2'(a);
    @(posedge clk); #(Q);
    chk(host_rdata == 8'(exp), tag, host_rdata, exp);
  endtask

  task automatic send_byte(input int cnt, input int d);
    host_write(1, d);
    host_write(0, cnt);
    idle(3);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    chk(1'b0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b1; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_port(0, 'hAA, "R1 port0");
    read_port(1, 'hBB, "R1 port1");
    read_port(2, 'h00, "R1 port2");
    read_port(3, 'h00, "R1 port3");
    chk(ram_we == 1'b0 && start == 1'b0, "R1 outputs", {ram_we, start}, 0);

    // R2 read strobe low
    @(negedge clk); host_rd = 1'b0; host_addr = 2'd1;
    @(posedge clk); #(Q);
    chk(host_rdata == 8'h00, "R2 rd low", host_rdata, 0);
    @(negedge clk); host_rd = 1'b1;

    // R3 pre-session write ignored
    host_write(0, 'h55);
    idle(3);
    read_port(0, 'hAA, "R3 no echo");
    chk(wr_cnt == 0, "R3 no write", wr_cnt, 0);

    // R4 session open, R5 first block at 0x1000
    host_write(1, 1); host_write(2, 'h00); host_write(3, 'h10);
    host_write(0, 'hCC);
    idle(3);
    read_port(0, 'hCC, "R4 kick echo");

    // R6 payload bytes
    send_byte(0, 'h11); read_port(0, 0, "R6 echo 0");
    send_byte(1, 'h22); read_port(0, 1, "R6 echo 1");
    send_byte(2, 'h33); read_port(0, 2, "R6 echo 2");
    chk(mem.exists('h1000) && mem['h1000] == 'h11, "R5 first byte", mem['h1000], 'h11);
    chk(mem['h1001] == 'h22, "R6 byte 1", mem['h1001], 'h22);
    chk(mem['h1002] == 'h33, "R6 byte 2", mem['h1002], 'h33);

    // R7 new block at 0xFFFE
    host_write(1, 2); host_write(2, 'hFE); host_write(3, 'hFF);
    host_write(0, 7);
    idle(3);
    read_port(0, 7, "R7 command echo");
    chk(wr_cnt == 3, "R7 no write on command", wr_cnt, 3);

    // R8 wrap
    send_byte(0, 'hA0);
    send_byte(1, 'hA1);
    send_byte(2, 'hA2);
    chk(mem['hFFFE] == 'hA0, "R8 byte FFFE", mem['hFFFE], 'hA0);
    chk(mem['hFFFF] == 'hA1, "R8 byte FFFF", mem['hFFFF], 'hA1);
    chk(mem.exists(0) && mem[0] == 'hA2, "R8 wrap to 0000", mem[0], 'hA2);

    // R9 execute
    host_write(1, 0); host_write(2, 'h34); host_write(3, 'h12);
    host_write(0, 'h10);
    idle(3);
    chk(start == 1'b1, "R9 start", start, 1);
    chk(entry_addr == 16'h1234, "R9 entry", entry_addr, 'h1234);
    read_port(0, 'h10, "R9 echo");

    // R10 ignored after start
    host_write(1, 'h99); host_write(0, 3);
    idle(4);
    read_port(0, 'h10, "R10 port0 held");
    chk(start == 1'b1, "R10 start held", start, 1);

    // R11 one pulse per accepted byte
    chk(wr_cnt == 6, "R11 write count", wr_cnt, 6);

    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule